// File: doc/BRIEF.md
# Serial Port Register File with Prioritised Interrupt Identification

This block is the host-side register front end of an asynchronous serial port in the classic byte-wide style. A host reaches eight byte registers through a 3-bit address with separate read and write strobes. Behind the registers sit a receive byte FIFO and a transmit byte FIFO. The serialiser and deserialiser are not part of the block. A receiver delivers each finished byte on a strobe, with parity, framing and break flags. A transmitter drains the transmit FIFO through a valid/pop handshake.

The block derives one interrupt line from five sources. The pending source with the highest priority is reported as a 4-bit identification code in the low nibble of the identification register. Line control bit 7 swaps offsets 0 and 1 over to the 16-bit baud divisor, which is driven out for an external baud generator. The modem status register has no external pins: its status bits are a loopback image of the modem control outputs.

Read data is combinational from the address. Read side effects (popping a received byte, clearing flags) take place at the clock edge that ends the read strobe.

Top module: `uart_regfile`

## Requirements
- R1: Offset 7 is a scratch register. A byte written there reads back unchanged, for example 0x55 reads back as 0x55.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. The `divisor` port shows the 16-bit value, and its reset value is 1. While bit 7 is 0, offset 0 is data and offset 1 is the interrupt enable register (bits 3:0), and the divisor is left unchanged.
- R3: Line control (offset 3) reads back as written and is driven on `line_ctrl`. Its fields are: bits 1:0 word length 5 to 8, bit 2 two stop bits, bits 5:3 parity (000 none, 001 odd, 011 even, 101 mark, 111 space).
- R4: A write to offset 2 is FIFO control. Bit 0 enables the FIFOs, and any change of bit 0 clears both FIFOs. Bit 1 clears the receive FIFO and bit 2 clears the transmit FIFO. Bits 7:6 set the receive trigger level (00: 1, 01: 4, 10: 8, 11: 14). Writing 0x87 gives enabled FIFOs, both empty, trigger 8. A read of offset 2 returns bits 7:6 as 11 when the FIFOs are enabled and 00 otherwise. With the FIFOs disabled, each FIFO holds one byte and the trigger level is 1.
- R5: The low nibble of offset 2 reads 0x1 when nothing is pending. Otherwise it reads 0x6 for line status, 0x4 for receive data, 0xC for character timeout, 0x2 for transmit holding empty, or 0x0 for modem status. `irq` is 1 exactly when a code other than 0x1 is reported.
- R6: When several sources are pending, only the highest is reported. The order, highest first, is: line status, then receive data or timeout, then transmit empty, then modem status.
- R7: Received bytes are read from offset 0 in arrival order. Line status bit 0 is 1 while any byte is unread. With interrupt enable bit 0 set, the receive data code is reported while the receive count is at or above the trigger level.
- R8: A byte that arrives while the receive FIFO is at capacity is dropped and sets line status bit 1 (overrun). A byte that arrives with its parity, framing or break flag sets line status bit 2, 3 or 4. Bit 7 is the OR of bits 2 to 4 when the FIFOs are enabled. Reading offset 5 clears bits 1 to 4. With interrupt enable bit 2 set, any of bits 1 to 4 raises the line status code.
- R9: In FIFO mode with interrupt enable bit 0 set, the timeout code is reported once the receive FIFO has been non-empty and below the trigger level, with no byte pushed and none read, for TIMEOUT_CYC clock cycles. A receive read or a new byte restarts the count.
- R10: The transmit-empty condition becomes pending when interrupt enable bit 1 goes from 0 to 1 with the transmit FIFO empty, or when the transmitter pops the last byte. A write to offset 0 (data mode) clears it, and so does a read of offset 2 that reports code 0x2.
- R11: Bytes written to offset 0 are offered on `tx_byte` with `tx_valid` in write order, and each `tx_pop` moves to the next byte. Line status bits 5 and 6 are 1 while the transmit FIFO is empty.
- R12: Modem control (offset 4, bits 4:0) reads back as written. Modem status bits 7:4 are a loopback image: bit 4 = control bit 1, bit 5 = control bit 0, bit 6 = control bit 2, bit 7 = control bit 3. Status bits 0, 1 and 3 set on any change of status bits 4, 5 and 7. Status bit 2 sets when status bit 6 falls. Reading offset 6 clears bits 3:0. With interrupt enable bit 3 set, any of bits 3:0 raises the modem status code.
- R13: After reset, the identification register reads 0x01, line status reads 0x60, modem status reads 0x00, `irq` is 0 and `divisor` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; side effects at the closing edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error for the received byte |
| rx_ferr | input | 1 | Framing error for the received byte |
| rx_brk | input | 1 | Break detected with the received byte |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_byte | output | 8 | Oldest byte in the transmit FIFO |
| tx_pop | input | 1 | Transmitter takes `tx_byte` |
| divisor | output | 16 | Baud divisor (115200 / baud) |
| line_ctrl | output | 8 | Line control register |

## Verification
The bound checker watches, on every cycle, the invariants that tie ports to FIFO state:
- divisor writes land in the latch;
- scratch writes read back;
- a FIFO flush empties both FIFOs;
- the FIFO signature tracks the enable;
- the data-ready bit follows the receive count;
- a timeout code appears only with a partly filled FIFO;
- a data write withdraws the transmit-empty code.

Only the bench scenarios can show the rest:
- the arrival order of bytes through the FIFOs;
- the exact cycle at which the timeout fires;
- how the identification code steps through the priorities as sources are cleared by reads;
- the loopback delta bits over random modem control sequences.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_IID   = 3'd2;
  localparam logic [2:0] OFS_LCTL  = 3'd3;
  localparam logic [2:0] OFS_MCTL  = 3'd4;
  localparam logic [2:0] OFS_LSTAT = 3'd5;
  localparam logic [2:0] OFS_MSTAT = 3'd6;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  typedef enum logic [3:0] {
    IID_MODEM  = 4'h0,
    IID_NONE   = 4'h1,
    IID_THRE   = 4'h2,
    IID_RXDATA = 4'h4,
    IID_LINE   = 4'h6,
    IID_TMO    = 4'hC
  } iid_code_e;

  // receive trigger level in bytes from FIFO control bits 7:6
  function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_bytes = 5'd1;
      2'b01:   trig_bytes = 5'd4;
      2'b10:   trig_bytes = 5'd8;
      default: trig_bytes = 5'd14;
    endcase
  endfunction

  // loopback image of modem control bits as status order {dcd, ri, dsr, cts}
  function automatic logic [3:0] loop_status(input logic [3:0] mctl);
    loop_status = {mctl[3], mctl[2], mctl[0], mctl[1]};
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_push = push && !clr && (cnt_q < CW'(DEPTH));
  assign do_pop  = pop && !clr && (cnt_q != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = bump(wr_ptr_q);
      if (do_pop)  rd_ptr_d = bump(rd_ptr_q);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int CYC = 64,
  localparam int TW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic restart,
  output logic expired
);

  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q;
    if (restart || !armed)       tmr_d = '0;
    else if (tmr_q != TW'(CYC))  tmr_d = tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign expired = armed && (tmr_q == TW'(CYC));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regs_pkg::*;
(
  input  logic      line_p,
  input  logic      rxd_p,
  input  logic      tmo_p,
  input  logic      thre_p,
  input  logic      msr_p,
  output iid_code_e code
);

  always_comb begin
    if (line_p)      code = IID_LINE;
    else if (rxd_p)  code = IID_RXDATA;
    else if (tmo_p)  code = IID_TMO;
    else if (thre_p) code = IID_THRE;
    else if (msr_p)  code = IID_MODEM;
    else             code = IID_NONE;
  end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int          FIFO_DEPTH  = 16,
  parameter int          TIMEOUT_CYC = 64,
  parameter logic [15:0] DIV_RESET   = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_pop,
  output logic [15:0] divisor,
  output logic [7:0]  line_ctrl
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  // architectural registers
  logic [7:0] dll_q, dll_d, dlm_q, dlm_d;
  logic [3:0] ien_q, ien_d;
  logic [7:0] lctl_q, lctl_d;
  logic [4:0] mctl_q, mctl_d;
  logic [7:0] scr_q, scr_d;
  logic       fen_q, fen_d;
  logic [1:0] tsel_q, tsel_d;
  logic       oe_q, oe_d, pe_q, pe_d, fe_q, fe_d, bi_q, bi_d;
  logic [3:0] mdelta_q, mdelta_d;
  logic       thre_q, thre_d;

  // decode
  logic dlab;
  logic wr_thr, wr_dll, wr_ien, wr_dlm, wr_fctl, wr_lctl, wr_mctl, wr_scr;
  logic rd_rbr, rd_iid, rd_lstat, rd_mstat;

  assign dlab     = lctl_q[7];
  assign wr_thr   = bus_wr && (bus_addr == OFS_DATA) && !dlab;
  assign wr_dll   = bus_wr && (bus_addr == OFS_DATA) &&  dlab;
  assign wr_ien   = bus_wr && (bus_addr == OFS_IEN)  && !dlab;
  assign wr_dlm   = bus_wr && (bus_addr == OFS_IEN)  &&  dlab;
  assign wr_fctl  = bus_wr && (bus_addr == OFS_IID);
  assign wr_lctl  = bus_wr && (bus_addr == OFS_LCTL);
  assign wr_mctl  = bus_wr && (bus_addr == OFS_MCTL);
  assign wr_scr   = bus_wr && (bus_addr == OFS_SCR);
  assign rd_rbr   = bus_rd && (bus_addr == OFS_DATA) && !dlab;
  assign rd_iid   = bus_rd && (bus_addr == OFS_IID);
  assign rd_lstat = bus_rd && (bus_addr == OFS_LSTAT);
  assign rd_mstat = bus_rd && (bus_addr == OFS_MSTAT);

  // FIFOs
  logic [CW-1:0] cap, rx_trig, rx_count, tx_count;
  logic [7:0]    rx_dout, tx_dout;
  logic          rx_clr, tx_clr, rx_accept, rx_drop, rx_take, tx_push, tx_take;

  assign cap     = fen_q ? CW'(FIFO_DEPTH) : CW'(1);
  assign rx_trig = fen_q ? CW'(trig_bytes(tsel_q)) : CW'(1);
  assign rx_clr  = wr_fctl && (bus_wdata[1] || (bus_wdata[0] != fen_q));
  assign tx_clr  = wr_fctl && (bus_wdata[2] || (bus_wdata[0] != fen_q));

  assign rx_accept = rx_valid && !rx_clr && (rx_count < cap);
  assign rx_drop   = rx_valid && !rx_clr && (rx_count >= cap);
  assign rx_take   = rd_rbr && (rx_count != '0);
  assign tx_push   = wr_thr && (tx_count < cap);
  assign tx_take   = tx_pop && (tx_count != '0);

  uart_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_accept), .din(rx_byte),
    .pop(rx_take), .dout(rx_dout), .count(rx_count)
  );

  uart_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(bus_wdata),
    .pop(tx_take), .dout(tx_dout), .count(tx_count)
  );

  // character timeout
  logic tmo_exp;

  uart_rx_timeout #(.CYC(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .armed(fen_q && (rx_count != '0)),
    .restart(rx_accept || rx_take),
    .expired(tmo_exp)
  );

  // interrupt sources and priority
  logic      line_err;
  logic [3:0] mstat;
  iid_code_e iid_code;

  assign line_err = oe_q || pe_q || fe_q || bi_q;
  assign mstat    = loop_status(mctl_q[3:0]);

  uart_irq_prio u_prio (
    .line_p (ien_q[2] && line_err),
    .rxd_p  (ien_q[0] && (rx_count >= rx_trig) && (rx_count != '0)),
    .tmo_p  (ien_q[0] && tmo_exp && (rx_count < rx_trig)),
    .thre_p (ien_q[1] && thre_q),
    .msr_p  (ien_q[3] && (mdelta_q != '0)),
    .code   (iid_code)
  );

  assign irq = (iid_code != IID_NONE);

  // next state
  logic [3:0] mstat_new;
  assign mstat_new = loop_status(bus_wdata[3:0]);

  always_comb begin
    dll_d    = dll_q;
    dlm_d    = dlm_q;
    ien_d    = ien_q;
    lctl_d   = lctl_q;
    mctl_d   = mctl_q;
    scr_d    = scr_q;
    fen_d    = fen_q;
    tsel_d   = tsel_q;
    oe_d     = oe_q;
    pe_d     = pe_q;
    fe_d     = fe_q;
    bi_d     = bi_q;
    mdelta_d = mdelta_q;
    thre_d   = thre_q;

    if (wr_dll)  dll_d  = bus_wdata;
    if (wr_dlm)  dlm_d  = bus_wdata;
    if (wr_ien)  ien_d  = bus_wdata[3:0];
    if (wr_lctl) lctl_d = bus_wdata;
    if (wr_mctl) mctl_d = bus_wdata[4:0];
    if (wr_scr)  scr_d  = bus_wdata;
    if (wr_fctl) begin
      fen_d  = bus_wdata[0];
      tsel_d = bus_wdata[7:6];
    end

    // line status error flags: read clears, new events win
    if (rd_lstat) begin
      oe_d = 1'b0;
      pe_d = 1'b0;
      fe_d = 1'b0;
      bi_d = 1'b0;
    end
    if (rx_drop) oe_d = 1'b1;
    if (rx_accept && rx_perr) pe_d = 1'b1;
    if (rx_accept && rx_ferr) fe_d = 1'b1;
    if (rx_accept && rx_brk)  bi_d = 1'b1;

    // modem status deltas from loopback changes
    if (rd_mstat) mdelta_d = '0;
    if (wr_mctl) begin
      mdelta_d[0] = mdelta_d[0] | (mstat_new[0] ^ mstat[0]);
      mdelta_d[1] = mdelta_d[1] | (mstat_new[1] ^ mstat[1]);
      mdelta_d[2] = mdelta_d[2] | (mstat[2] & ~mstat_new[2]);
      mdelta_d[3] = mdelta_d[3] | (mstat_new[3] ^ mstat[3]);
    end

    // transmit holding empty condition
    if (wr_thr) thre_d = 1'b0;
    if (rd_iid && (iid_code == IID_THRE)) thre_d = 1'b0;
    if (tx_take && (tx_count == CW'(1)) && !tx_push) thre_d = 1'b1;
    if (wr_ien && bus_wdata[1] && !ien_q[1] && (tx_count == '0)) thre_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_q    <= DIV_RESET[7:0];
      dlm_q    <= DIV_RESET[15:8];
      ien_q    <= '0;
      lctl_q   <= '0;
      mctl_q   <= '0;
      scr_q    <= '0;
      fen_q    <= 1'b0;
      tsel_q   <= '0;
      oe_q     <= 1'b0;
      pe_q     <= 1'b0;
      fe_q     <= 1'b0;
      bi_q     <= 1'b0;
      mdelta_q <= '0;
      thre_q   <= 1'b0;
    end else begin
      dll_q    <= dll_d;
      dlm_q    <= dlm_d;
      ien_q    <= ien_d;
      lctl_q   <= lctl_d;
      mctl_q   <= mctl_d;
      scr_q    <= scr_d;
      fen_q    <= fen_d;
      tsel_q   <= tsel_d;
      oe_q     <= oe_d;
      pe_q     <= pe_d;
      fe_q     <= fe_d;
      bi_q     <= bi_d;
      mdelta_q <= mdelta_d;
      thre_q   <= thre_d;
    end
  end

  // read mux
  logic [7:0] lstat;
  assign lstat = {fen_q && (pe_q || fe_q || bi_q), tx_count == '0, tx_count == '0,
                  bi_q, fe_q, pe_q, oe_q, rx_count != '0};

  always_comb begin
    case (bus_addr)
      OFS_DATA:  bus_rdata = dlab ? dll_q : ((rx_count != '0) ? rx_dout : 8'h00);
      OFS_IEN:   bus_rdata = dlab ? dlm_q : {4'b0000, ien_q};
      OFS_IID:   bus_rdata = {fen_q, fen_q, 2'b00, iid_code};
      OFS_LCTL:  bus_rdata = lctl_q;
      OFS_MCTL:  bus_rdata = {3'b000, mctl_q};
      OFS_LSTAT: bus_rdata = lstat;
      OFS_MSTAT: bus_rdata = {mstat, mdelta_q};
      default:   bus_rdata = scr_q;
    endcase
  end

  assign tx_valid  = (tx_count != '0);
  assign tx_byte   = tx_valid ? tx_dout : 8'h00;
  assign divisor   = {dlm_q, dll_q};
  assign line_ctrl = lctl_q;

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_addr,
  input logic          bus_wr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic [15:0]   divisor,
  input logic          dlab,
  input logic          fen,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_trig,
  input logic [3:0]    iid
);

  // R2
  divisor_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && dlab) |=> (divisor[7:0] == $past(bus_wdata)));

  // R1
  scratch_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd7) |=> (bus_addr != 3'd7 || bus_wr || bus_rdata == $past(bus_wdata)));

  // R4
  fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && bus_wdata[2:1] == 2'b11) |=> (rx_count == '0 && tx_count == '0));

  // R4
  fifo_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd2) |-> (bus_rdata[7:6] == {fen, fen}));

  // R7
  data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd5) |-> (bus_rdata[0] == (rx_count != '0)));

  // R9
  tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iid == 4'hC) |-> (fen && rx_count != '0 && rx_count < rx_trig));

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  // R10
  thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && !dlab) |=> (iid != 4'h2));

endmodule

bind uart_regfile uart_regfile_chk #(.CW(CW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .divisor(divisor),
  .dlab(dlab), .fen(fen_q), .rx_count(rx_count), .tx_count(tx_count),
  .rx_trig(rx_trig), .iid(iid_code)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;

  localparam int TMO   = 64;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        irq;
  logic        rx_valid, rx_perr, rx_ferr, rx_brk;
  logic [7:0]  rx_byte;
  logic        tx_valid, tx_pop;
  logic [7:0]  tx_byte;
  logic [15:0] divisor;
  logic [7:0]  line_ctrl;

  always #10 clk = ~clk;

  uart_regfile #(.FIFO_DEPTH(DEPTH), .TIMEOUT_CYC(TMO), .DIV_RESET(16'd1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_brk(rx_brk), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_pop(tx_pop),
    .divisor(divisor), .line_ctrl(line_ctrl)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] d;
  logic [7:0] q [$];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #5 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b, input logic pe);
    rx_byte = b; rx_perr = pe; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    tx_pop = 1'b1;
    #5 b = tx_byte;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  function automatic logic [3:0] st_of(input logic [4:0] m);
    st_of = {m[3], m[2], m[0], m[1]};
  endfunction

  function automatic logic [3:0] delta_of(input logic [4:0] o, input logic [4:0] n);
    logic [3:0] so, sn;
    so = st_of(o); sn = st_of(n);
    delta_of = {so[3] ^ sn[3], so[2] & ~sn[2], so[1] ^ sn[1], so[0] ^ sn[0]};
  endfunction

  function automatic logic [7:0] exp_lsr(input int rxn, input int txn, input logic oe,
                                         input logic pe, input logic fen);
    exp_lsr = {fen & pe, txn == 0, txn == 0, 2'b00, pe, oe, rxn != 0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [4:0] mm;
    logic [3:0] md;
    int unsigned seed;
    seed = $urandom(32'd2024);
    bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    rx_valid = 0; rx_byte = '0; rx_perr = 0; rx_ferr = 0; rx_brk = 0; tx_pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(3'd2, d); chk("R13 iid", d, 8'h01);
    rd(3'd5, d); chk("R13 lsr", d, 8'h60);
    rd(3'd6, d); chk("R13 msr", d, 8'h00);
    chk("R13 irq", irq, 0);
    chk("R13 divisor", divisor, 16'd1);

    // R1 scratch
    wr(3'd7, 8'h55); rd(3'd7, d); chk("R1 scratch 55", d, 8'h55);
    for (int i = 0; i < 8; i++) begin
      b = 8'($urandom);
      wr(3'd7, b); rd(3'd7, d); chk("R1 scratch random", d, b);
    end

    // R3 line control
    wr(3'd3, 8'h1F); rd(3'd3, d); chk("R3 lctl readback", d, 8'h1F);
    chk("R3 line_ctrl port", line_ctrl, 8'h1F);

    // R2 divisor overlay
    wr(3'd3, 8'h9F);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] dv;
      dv = 16'($urandom);
      wr(3'd0, dv[7:0]); wr(3'd1, dv[15:8]);
      rd(3'd0, d); chk("R2 dll read", d, dv[7:0]);
      rd(3'd1, d); chk("R2 dlm read", d, dv[15:8]);
      chk("R2 divisor port", divisor, dv);
    end
    chk("R2 divisor write leaves tx", tx_valid, 0);
    wr(3'd0, 8'h01); wr(3'd1, 8'h00);
    wr(3'd3, 8'h1F);
    wr(3'd1, 8'h00); rd(3'd1, d); chk("R2 ien at offset1", d, 8'h00);
    chk("R2 divisor kept", divisor, 16'd1);

    // R4 FIFO enable
    wr(3'd2, 8'h87); rd(3'd2, d); chk("R4 iid fifo sig", d, 8'hC1);

    // R7 trigger level 8
    wr(3'd1, 8'h01);
    q.delete();
    for (int i = 0; i < 7; i++) begin b = 8'($urandom); q.push_back(b); push_rx(b, 0); end
    rd(3'd2, d); chk("R7 below trigger", d, 8'hC1);
    chk("R7 irq below trigger", irq, 0);
    b = 8'($urandom); q.push_back(b); push_rx(b, 0);
    rd(3'd2, d); chk("R7 at trigger", d, 8'hC4);
    chk("R7 irq at trigger", irq, 1);
    rd(3'd5, d); chk("R7 lsr ready", d, exp_lsr(8, 0, 0, 0, 1));
    rd(3'd0, d); chk("R7 first byte", d, q.pop_front());
    rd(3'd2, d); chk("R7 drop below trigger", d, 8'hC1);
    while (q.size() > 0) begin rd(3'd0, d); chk("R7 order", d, q.pop_front()); end
    rd(3'd5, d); chk("R7 lsr empty", d, 8'h60);

    // R7 random bursts
    wr(3'd1, 8'h00);
    for (int r = 0; r < 5; r++) begin
      int n;
      n = 1 + int'($urandom % DEPTH);
      for (int i = 0; i < n; i++) begin b = 8'($urandom); q.push_back(b); push_rx(b, 0); end
      rd(3'd5, d); chk("R7 burst lsr", d, exp_lsr(n, 0, 0, 0, 1));
      while (q.size() > 0) begin rd(3'd0, d); chk("R7 burst order", d, q.pop_front()); end
    end

    // R9 timeout
    wr(3'd1, 8'h01);
    push_rx(8'hA1, 0); push_rx(8'hA2, 0);
    repeat (TMO - 4) @(negedge clk);
    rd(3'd2, d); chk("R9 before timeout", d, 8'hC1);
    repeat (8) @(negedge clk);
    chk("R9 irq timeout", irq, 1);
    rd(3'd2, d); chk("R9 timeout code", d, 8'hCC);
    rd(3'd0, d); chk("R9 byte1", d, 8'hA1);
    rd(3'd2, d); chk("R9 restart", d, 8'hC1);
    rd(3'd0, d); chk("R9 byte2", d, 8'hA2);

    // R8 overrun in FIFO mode, R6 line above data
    wr(3'd1, 8'h05); wr(3'd2, 8'h87);
    for (int i = 0; i < DEPTH; i++) begin b = 8'($urandom); q.push_back(b); push_rx(b, 0); end
    push_rx(8'hEE, 0);
    rd(3'd2, d); chk("R6 line over data", d, 8'hC6);
    rd(3'd5, d); chk("R8 overrun lsr", d, exp_lsr(DEPTH, 0, 1, 0, 1));
    rd(3'd2, d); chk("R8 lsr read clears", d, 8'hC4);
    while (q.size() > 0) begin rd(3'd0, d); chk("R8 kept bytes", d, q.pop_front()); end
    push_rx(8'h3C, 1);
    rd(3'd5, d); chk("R8 parity lsr", d, exp_lsr(1, 0, 0, 1, 1));
    rd(3'd5, d); chk("R8 parity cleared", d, exp_lsr(1, 0, 0, 0, 1));
    rd(3'd0, d); chk("R8 parity byte", d, 8'h3C);

    // R4/R8 non-FIFO mode, single byte holding
    wr(3'd2, 8'h00);
    rd(3'd2, d); chk("R4 no fifo sig", d, 8'h01);
    push_rx(8'h11, 0); push_rx(8'h22, 0);
    rd(3'd2, d); chk("R8 line code", d, 8'h06);
    rd(3'd5, d); chk("R8 single overrun", d, exp_lsr(1, 0, 1, 0, 0));
    rd(3'd0, d); chk("R8 held byte", d, 8'h11);
    rd(3'd5, d); chk("R8 lsr idle", d, 8'h60);

    // R10/R11 transmit
    wr(3'd1, 8'h00); wr(3'd2, 8'h87);
    wr(3'd1, 8'h02);
    chk("R10 irq on enable", irq, 1);
    rd(3'd2, d); chk("R10 thre code", d, 8'hC2);
    rd(3'd2, d); chk("R10 iid read clears", d, 8'hC1);
    for (int i = 0; i < 3; i++) begin b = 8'($urandom); q.push_back(b); wr(3'd0, b); end
    chk("R11 tx_valid", tx_valid, 1);
    rd(3'd5, d); chk("R11 lsr tx busy", d, exp_lsr(0, 3, 0, 0, 1));
    while (q.size() > 0) begin pop_tx(b); chk("R11 tx order", b, q.pop_front()); end
    chk("R11 tx drained", tx_valid, 0);
    rd(3'd2, d); chk("R10 empty again", d, 8'hC2);
    rd(3'd5, d); chk("R11 lsr empty", d, 8'h60);
    wr(3'd0, 8'h5A);
    rd(3'd2, d); chk("R10 write clears", d, 8'hC1);
    pop_tx(b); chk("R11 single byte", b, 8'h5A);

    // R6 transmit over modem, R12
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h01);
    wr(3'd1, 8'h0A);
    rd(3'd2, d); chk("R6 thre over modem", d, 8'hC2);
    rd(3'd2, d); chk("R6 modem next", d, 8'hC0);
    rd(3'd6, d); chk("R12 msr dsr", d, 8'h22);
    rd(3'd2, d); chk("R12 msr read clears", d, 8'hC1);

    // R12 random loopback
    wr(3'd1, 8'h08);
    mm = 5'h01; md = 4'h0;
    for (int i = 0; i < 24; i++) begin
      logic [4:0] nm;
      nm = 5'($urandom);
      md = md | delta_of(mm, nm);
      mm = nm;
      wr(3'd4, {3'b000, nm});
      chk("R12 irq delta", irq, md != 0);
      if ($urandom % 2 == 1) begin
        rd(3'd6, d); chk("R12 msr", d, {st_of(mm), md});
        md = 4'h0;
        rd(3'd4, d); chk("R12 mctl readback", d, {3'b000, mm});
      end
    end
    rd(3'd6, d);
    wr(3'd4, 8'h04); rd(3'd6, d);
    wr(3'd4, 8'h00);
    rd(3'd6, d); chk("R12 ri falling", d, 8'h04);
    chk("R5 irq idle", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule